// File: doc/BRIEF.md
# PWM Output Pair Override Logic

This block turns four raw duty-compare signals into eight registered pin states, organised as four high/low pairs. Each pair runs either in independent mode, where both pins take the same duty signal and may be active together, or in complementary mode, where the low pin carries the inverse of the high pin's drive and both pins are held inactive for a programmable dead time after each change of that drive.

Any pin can be taken over manually through an 8-bit override-enable field and an 8-bit override-level field. The block holds these fields in an active copy. With synchronisation off, the active copy reloads on every clock. With synchronisation on, it reloads only on time-base events: a counter-at-zero strobe in edge-aligned operation, and also a period-match strobe in center-aligned operation. The time base and the duty comparators sit outside the block and reach it as single-cycle strobes and levels.

Top module: `pwm_pair_override`

## Requirements
- R1: While `rst_n` is low, every pin is driven to 0 at each rising edge, and the active override copy is cleared, so no pin is overridden.
- R2: A pair whose `indep_mode` bit is 1 drives both pins from its own `duty_raw` bit with no dead time, so both pins can be 1 at once.
- R3: In independent mode an overridden pin drives its override level (1 = active, 0 = inactive), whatever the duty signal is.
- R4: In complementary mode (`indep_mode` bit 0) the high pin follows the pair's drive signal and the low pin its inverse; the two pins are never both 1.
- R5: In complementary mode, each change of the drive signal holds both pins at 0 for exactly `dead_cnt` clock cycles before the new levels appear; a `dead_cnt` of 0 inserts no dead time.
- R6: Override bit i (0..3) of `ovr_en` and `ovr_lvl` belongs to the low pin of pair i, and bit 4+i belongs to the high pin of pair i.
- R7: In complementary mode an overridden low pin with level 1 outputs the complement of its pair's high drive, and with level 0 it is held at 0.
- R8: In complementary mode an overridden high pin sets the pair's drive signal to its level, and a change of that level gets the same dead time as a duty change.
- R9: With `sync_en` at 0, override fields present at a rising edge are loaded into the active copy at that edge and reach the pins at the following edge.
- R10: With `sync_en` at 1 and `center_mode` at 0, the active override copy changes only at an edge where `tb_zero` is 1; `tb_period` has no effect.
- R11: With `sync_en` at 1 and `center_mode` at 1, the active override copy is reloaded at an edge where either `tb_zero` or `tb_period` is 1.
- R12: Every pin is a register output: a duty change at the pins' inputs appears one clock later when no dead time applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| duty_raw | input | 4 | Raw duty-compare result, one bit per pair |
| indep_mode | input | 4 | 1 = pair in independent mode, 0 = complementary |
| ovr_en | input | 8 | Override enables; bits 3:0 low pins, bits 7:4 high pins |
| ovr_lvl | input | 8 | Override levels, same bit layout as `ovr_en` |
| dead_cnt | input | 6 | Dead time in clock cycles |
| sync_en | input | 1 | 1 = override updates wait for time-base events |
| tb_zero | input | 1 | Time-base counter at zero strobe |
| tb_period | input | 1 | Time-base period match strobe |
| center_mode | input | 1 | 1 = center-aligned time base, 0 = edge-aligned |
| pin_hi | output | 4 | High pin of each pair |
| pin_lo | output | 4 | Low pin of each pair |

## Verification
On every cycle the assertions check that the active override copy holds between synchronising events and reloads when it should, that a complementary pair never has both pins active, that a drive change in complementary mode blanks both pins on the next cycle, and that independent pairs pass their levels straight through. Only the bench scenarios show the full length of the dead time for a given count, the complement rule of an overridden low pin, the pin-to-bit mapping of the override fields, and the two-clock path from an override write to the pins, since these depend on a sequence of inputs and are compared against a cycle-by-cycle reference model.

// File: rtl/pwm_ovr_pkg.sv
// Shared types and helpers for the PWM pair override logic.
// Assumes one override record per output pair.
package pwm_ovr_pkg;

    // Override controls that apply to a single high/low pair.
    typedef struct packed {
        logic en_hi;
        logic en_lo;
        logic lvl_hi;
        logic lvl_lo;
    } pin_ovr_t;

    // True when the time base offers an override reload point.
    function automatic logic sync_strobe(input logic center, input logic at_zero,
                                         input logic at_period);
        return at_zero | (center & at_period);
    endfunction

endpackage

// File: rtl/ovr_shadow.sv
// Active copy of the override enable and level fields.
// Reloads on every clock when synchronisation is off, otherwise only at
// time-base reload points. Assumes strobes last one clock each.
module ovr_shadow
    import pwm_ovr_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sync_en,
    input  logic            center_mode,
    input  logic            tb_zero,
    input  logic            tb_period,
    input  logic [PINS-1:0] ovr_en_in,
    input  logic [PINS-1:0] ovr_lvl_in,
    output logic [PINS-1:0] act_en,
    output logic [PINS-1:0] act_lvl
);

    logic take;

    // Decide whether this edge reloads the active copy.
    always_comb begin
        take = !sync_en || sync_strobe(center_mode, tb_zero, tb_period);
    end

    // Hold or reload the active override fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_en  <= '0;
            act_lvl <= '0;
        end else if (take) begin
            act_en  <= ovr_en_in;
            act_lvl <= ovr_lvl_in;
        end
    end

    AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_en && !tb_zero && !(center_mode && tb_period)) |=> ($stable(act_en) && $stable(act_lvl))); // R10

    AST_NOSYNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_en |=> (act_en == $past(ovr_en_in) && act_lvl == $past(ovr_lvl_in))); // R9

    AST_CENTER_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_en && center_mode && tb_period) |=> (act_en == $past(ovr_en_in))); // R11

endmodule

// File: rtl/pair_mode_mux.sv
// Combinational mode and override selection for one pair.
// Produces the pair's drive signal and the requested pin levels before
// dead time. Assumes the override record is already the active copy.
module pair_mode_mux
    import pwm_ovr_pkg::*;
(
    input  logic     duty,
    input  logic     indep,
    input  pin_ovr_t ovr,
    output logic     drv,
    output logic     hi_req,
    output logic     lo_req
);

    // Select the drive and the requested high/low levels.
    always_comb begin
        drv    = ovr.en_hi ? ovr.lvl_hi : duty;
        hi_req = drv;
        if (indep) begin
            lo_req = ovr.en_lo ? ovr.lvl_lo : duty;
        end else begin
            lo_req = ovr.en_lo ? (ovr.lvl_lo & ~drv) : ~drv;
        end
    end

endmodule

// File: rtl/pair_dead_time.sv
// Dead-time blanking and output registers for one pair.
// In complementary mode a change of the drive signal holds both pins at 0
// for dead_cnt cycles; independent mode passes the requests straight on.
module pair_dead_time #(
    parameter int DT_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            indep,
    input  logic            drv,
    input  logic            hi_req,
    input  logic            lo_req,
    input  logic [DT_W-1:0] dead_cnt,
    output logic            pin_hi,
    output logic            pin_lo
);

    logic            drv_q;
    logic [DT_W-1:0] remain;
    logic [DT_W-1:0] remain_nx;
    logic            flip;
    logic            blank;

    // Detect drive changes and work out the blanking window.
    always_comb begin
        flip = !indep && (drv != drv_q);
        if (indep) begin
            blank     = 1'b0;
            remain_nx = '0;
        end else if (flip) begin
            blank     = (dead_cnt != '0);
            remain_nx = blank ? dead_cnt - DT_W'(1) : '0;
        end else begin
            blank     = (remain != '0);
            remain_nx = blank ? remain - DT_W'(1) : '0;
        end
    end

    // Track the previous drive and the remaining blank cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_q  <= 1'b0;
            remain <= '0;
        end else begin
            drv_q  <= drv;
            remain <= remain_nx;
        end
    end

    // Register the pins, forcing both low while blanking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_hi <= 1'b0;
            pin_lo <= 1'b0;
        end else begin
            pin_hi <= hi_req & ~blank;
            pin_lo <= lo_req & ~blank;
        end
    end

    AST_DT_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (flip && dead_cnt != '0) |=> (!pin_hi && !pin_lo)); // R5

    AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
        !indep |=> !(pin_hi && pin_lo)); // R4

    AST_INDEP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        indep |=> (pin_hi == $past(hi_req) && pin_lo == $past(lo_req))); // R2

    AST_DT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!indep && !flip && remain == '0) |=> (pin_hi == $past(hi_req))); // R5

endmodule

// File: rtl/pwm_pair_override.sv
// Top of the PWM pair override logic: one active override copy shared by
// all pairs, then per pair a mode/override mux and a dead-time stage.
// Override bit i is the low pin of pair i, bit NUM_PAIRS+i the high pin.
module pwm_pair_override
    import pwm_ovr_pkg::*;
#(
    parameter int NUM_PAIRS = 4,
    parameter int DT_W      = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_PAIRS-1:0]   duty_raw,
    input  logic [NUM_PAIRS-1:0]   indep_mode,
    input  logic [2*NUM_PAIRS-1:0] ovr_en,
    input  logic [2*NUM_PAIRS-1:0] ovr_lvl,
    input  logic [DT_W-1:0]        dead_cnt,
    input  logic                   sync_en,
    input  logic                   tb_zero,
    input  logic                   tb_period,
    input  logic                   center_mode,
    output logic [NUM_PAIRS-1:0]   pin_hi,
    output logic [NUM_PAIRS-1:0]   pin_lo
);

    localparam int PINS = 2 * NUM_PAIRS;

    logic [PINS-1:0] act_en;
    logic [PINS-1:0] act_lvl;

    ovr_shadow #(.PINS(PINS)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_en    (sync_en),
        .center_mode(center_mode),
        .tb_zero    (tb_zero),
        .tb_period  (tb_period),
        .ovr_en_in  (ovr_en),
        .ovr_lvl_in (ovr_lvl),
        .act_en     (act_en),
        .act_lvl    (act_lvl)
    );

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        pin_ovr_t pov;
        logic     drv;
        logic     hi_req;
        logic     lo_req;

        // Gather this pair's override bits from the shared fields.
        always_comb begin
            pov.en_hi  = act_en[NUM_PAIRS+p];
            pov.en_lo  = act_en[p];
            pov.lvl_hi = act_lvl[NUM_PAIRS+p];
            pov.lvl_lo = act_lvl[p];
        end

        pair_mode_mux u_mux (
            .duty  (duty_raw[p]),
            .indep (indep_mode[p]),
            .ovr   (pov),
            .drv   (drv),
            .hi_req(hi_req),
            .lo_req(lo_req)
        );

        pair_dead_time #(.DT_W(DT_W)) u_dt (
            .clk     (clk),
            .rst_n   (rst_n),
            .indep   (indep_mode[p]),
            .drv     (drv),
            .hi_req  (hi_req),
            .lo_req  (lo_req),
            .dead_cnt(dead_cnt),
            .pin_hi  (pin_hi[p]),
            .pin_lo  (pin_lo[p])
        );
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (pin_hi == '0 && pin_lo == '0)); // R1

endmodule

// File: tb/tb_pwm_pair_override.sv
module tb_pwm_pair_override;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] duty_raw = '0;
    logic [3:0] indep_mode = '0;
    logic [7:0] ovr_en = '0;
    logic [7:0] ovr_lvl = '0;
    logic [5:0] dead_cnt = '0;
    logic       sync_en = 1'b0;
    logic       tb_zero = 1'b0;
    logic       tb_period = 1'b0;
    logic       center_mode = 1'b0;
    logic [3:0] pin_hi;
    logic [3:0] pin_lo;

    int    errors = 0;
    int    checks = 0;
    int    wd = 0;
    string cur_req = "R1";

    // reference model state
    logic [7:0] m_en = '0;
    logic [7:0] m_lvl = '0;
    bit         m_prev[4];
    int         m_rem[4];
    logic [3:0] exp_hi = '0;
    logic [3:0] exp_lo = '0;

    always #4 clk = ~clk;   // 125 MHz

    pwm_pair_override dut (
        .clk(clk), .rst_n(rst_n), .duty_raw(duty_raw), .indep_mode(indep_mode),
        .ovr_en(ovr_en), .ovr_lvl(ovr_lvl), .dead_cnt(dead_cnt), .sync_en(sync_en),
        .tb_zero(tb_zero), .tb_period(tb_period), .center_mode(center_mode),
        .pin_hi(pin_hi), .pin_lo(pin_lo)
    );

    // behavioural model, advanced once per rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = '0; m_lvl = '0; exp_hi = '0; exp_lo = '0;
            for (int p = 0; p < 4; p++) begin m_prev[p] = 0; m_rem[p] = 0; end
        end else begin
            for (int p = 0; p < 4; p++) begin
                bit d, h, l;
                d = m_en[4+p] ? m_lvl[4+p] : duty_raw[p];
                if (indep_mode[p]) begin
                    h = d;
                    l = m_en[p] ? m_lvl[p] : duty_raw[p];
                    m_rem[p] = 0;
                end else begin
                    h = d;
                    l = m_en[p] ? (m_lvl[p] && !d) : !d;
                    if (d != m_prev[p]) m_rem[p] = int'(dead_cnt);
                    if (m_rem[p] > 0) begin
                        h = 0; l = 0; m_rem[p] = m_rem[p] - 1;
                    end
                end
                m_prev[p] = d;
                exp_hi[p] = h;
                exp_lo[p] = l;
            end
            if (!sync_en || tb_zero || (center_mode && tb_period)) begin
                m_en = ovr_en; m_lvl = ovr_lvl;
            end
        end
    end

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        checks++;
        if (pin_hi !== exp_hi || pin_lo !== exp_lo) begin
            errors++;
            $display("FAIL %s cycle compare: hi=%b lo=%b expected hi=%b lo=%b",
                     cur_req, pin_hi, pin_lo, exp_hi, exp_lo);
        end
    end

    // watchdog
    always @(posedge clk) begin
        wd++;
        if (wd > 20000) begin
            errors++;
            $display("FAIL watchdog expired: cycles=%0d expected<=20000", wd);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [7:0] act,
                       input logic [7:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    initial begin
        cur_req = "R1";
        tick(3);
        chk(pin_hi == 4'h0 && pin_lo == 4'h0, "R1 reset pins", {pin_hi, pin_lo}, 8'h00);
        ovr_en = 8'hFF; ovr_lvl = 8'hFF;   // ignored by reset
        tick(2);
        chk(pin_hi == 4'h0 && pin_lo == 4'h0, "R1 reset holds", {pin_hi, pin_lo}, 8'h00);
        ovr_en = '0; ovr_lvl = '0;
        rst_n = 1'b1;

        // independent mode, duty patterns
        cur_req = "R2"; indep_mode = 4'hF; dead_cnt = 6'd5;
        duty_raw = 4'hF; tick(1);
        chk(pin_hi == 4'hF && pin_lo == 4'hF, "R12 one clock latency", {pin_hi, pin_lo}, 8'hFF);
        chk(pin_hi == 4'hF && pin_lo == 4'hF, "R2 both pins active", {pin_hi, pin_lo}, 8'hFF);
        for (int k = 0; k < 16; k++) begin duty_raw = 4'(k * 5 + 3); tick(1); end
        duty_raw = 4'h5; tick(2);
        chk(pin_hi == 4'h5 && pin_lo == 4'h5, "R2 pattern 5", {pin_hi, pin_lo}, 8'h55);

        // independent overrides and bit mapping
        cur_req = "R3"; duty_raw = 4'h0;
        ovr_en = 8'b0010_0001; ovr_lvl = 8'b0010_0001; tick(1);
        chk(pin_hi == 4'h0 && pin_lo == 4'h0, "R9 not yet at pins", {pin_hi, pin_lo}, 8'h00);
        tick(1);
        chk(pin_hi == 4'b0010 && pin_lo == 4'b0001, "R6 bit mapping", {pin_hi, pin_lo}, 8'h21);
        duty_raw = 4'hF; ovr_en = 8'b1000_0100; ovr_lvl = 8'h00; tick(2);
        chk(pin_hi == 4'b0111 && pin_lo == 4'b1011, "R3 forced inactive", {pin_hi, pin_lo}, 8'h7B);
        ovr_en = 8'h00; tick(2);

        // complementary with dead time
        cur_req = "R5"; indep_mode = 4'h0; duty_raw = 4'h0; dead_cnt = 6'd3; tick(6);
        chk(pin_hi == 4'h0 && pin_lo == 4'hF, "R4 low is inverse", {pin_hi, pin_lo}, 8'h0F);
        duty_raw = 4'h1;
        begin
            int zeros = 0;
            for (int k = 0; k < 10; k++) begin
                tick(1);
                if (pin_hi[0]) break;
                if (!pin_lo[0]) zeros++;
            end
            chk(zeros == 3 && pin_hi[0], "R5 blank length 3", 8'(zeros), 8'd3);
        end
        cur_req = "R4";
        for (int k = 0; k < 40; k++) begin
            duty_raw = 4'(k * 7);
            tick((k % 5) + 1);
        end
        dead_cnt = 6'd0; duty_raw = 4'h0; tick(2); duty_raw = 4'hA; tick(1);
        chk(pin_hi == 4'hA && pin_lo == 4'h5, "R5 zero dead time", {pin_hi, pin_lo}, 8'hA5);

        // complementary overrides
        cur_req = "R7"; dead_cnt = 6'd2; duty_raw = 4'h3; tick(4);
        ovr_en = 8'h0F; ovr_lvl = 8'h0F; tick(4);
        chk(pin_lo == 4'hC, "R7 low level 1 gives complement", {4'h0, pin_lo}, 8'h0C);
        ovr_lvl = 8'h00; tick(3);
        chk(pin_lo == 4'h0, "R7 low level 0 inactive", {4'h0, pin_lo}, 8'h00);
        cur_req = "R8"; ovr_en = 8'hF0; ovr_lvl = 8'h50; tick(1); tick(1);
        chk(pin_hi[2] == 1'b0 && pin_lo[2] == 1'b0, "R8 override change blanks", {pin_hi, pin_lo}, 8'h00);
        tick(3);
        chk(pin_hi == 4'h5 && pin_lo == 4'hA, "R8 override drive", {pin_hi, pin_lo}, 8'h5A);
        ovr_lvl = 8'hA0; tick(6);
        ovr_en = 8'h00; tick(4);

        // synchronised, edge-aligned
        cur_req = "R10"; sync_en = 1'b1; center_mode = 1'b0; dead_cnt = 6'd1;
        indep_mode = 4'hF; duty_raw = 4'h0; tick(2);
        ovr_en = 8'hFF; ovr_lvl = 8'hFF; tick(4);
        chk(pin_hi == 4'h0 && pin_lo == 4'h0, "R10 held without event", {pin_hi, pin_lo}, 8'h00);
        tb_period = 1'b1; tick(1); tb_period = 1'b0; tick(3);
        chk(pin_hi == 4'h0 && pin_lo == 4'h0, "R10 period ignored", {pin_hi, pin_lo}, 8'h00);
        tb_zero = 1'b1; tick(1); tb_zero = 1'b0; tick(1);
        chk(pin_hi == 4'hF && pin_lo == 4'hF, "R10 zero reloads", {pin_hi, pin_lo}, 8'hFF);

        // synchronised, center-aligned
        cur_req = "R11"; center_mode = 1'b1; ovr_lvl = 8'h00; tick(3);
        chk(pin_hi == 4'hF, "R11 held without event", {pin_hi, pin_lo}, 8'hFF);
        tb_period = 1'b1; tick(1); tb_period = 1'b0; tick(1);
        chk(pin_hi == 4'h0 && pin_lo == 4'h0, "R11 period reloads", {pin_hi, pin_lo}, 8'h00);
        ovr_lvl = 8'h3C; tb_zero = 1'b1; tick(1); tb_zero = 1'b0; tick(1);
        chk(pin_hi == 4'h3 && pin_lo == 4'hC, "R11 zero reloads", {pin_hi, pin_lo}, 8'h3C);
        indep_mode = 4'h0;
        for (int k = 0; k < 30; k++) begin
            ovr_lvl = 8'(k * 37); duty_raw = 4'(k);
            tb_zero = (k % 4 == 0); tb_period = (k % 4 == 2);
            tick(1);
        end
        tb_zero = 0; tb_period = 0; tick(8);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule